// File: doc/BRIEF.md
# Serial Preamble and Start-Delimiter Detector

This block sits at the front of a serial receiver for a shared, carrier-sensed link. It watches a recovered bit stream, one bit per cycle in which the bit-valid strobe is high, while the carrier input reports that the line is busy. It looks for a run of alternating ones and zeros followed by a start delimiter made of two ones in a row. The second one of that pair closes the preamble. The block then raises a one-cycle frame-start pulse, so that the logic downstream treats the next valid bit as the first address bit.

The delimiter counts as part of the preamble. A preamble that holds two zeros in a row, or that reaches the delimiter before the configured number of alternating bits, is rejected. The block then gives a one-cycle invalid-preamble pulse and ignores the rest of that carrier period.

The required run length comes from a 2-bit select. Code 1 asks for 8 bits, code 2 for 32 and code 3 for 64, and each of these counts is a parameter. Code 0 would mean a zero-length preamble, which cannot carry a delimiter. The block does not support it and stays silent for that carrier period.

The controller has five states:
- **IDLE**: waits for carrier and samples the select.
- **RUN**: checks the alternating run.
- **FRAME**: the delimiter was accepted.
- **DISCARD**: the preamble was rejected.
- **UNSUP**: the select was code 0.

It has these transitions:
- IDLE→RUN: carrier seen, select nonzero.
- IDLE→UNSUP: carrier seen, select zero.
- RUN→FRAME: two ones with the run met.
- RUN→DISCARD: two zeros, or two ones before the run is met.
- FRAME, DISCARD, UNSUP or RUN→IDLE: carrier low.

Top module: `preamble_detector`

## Requirements
- R1: During and right after reset, frame_start, preamble_bad and in_frame are low.
- R2: The run counts bits that differ from the bit before them, including the first one of the delimiter. When the second one of a delimiter arrives and the run holds at least N bits, frame_start is high for exactly the one cycle after the clock edge that captured that bit. N is 8, 32 or 64 for len_sel 1, 2 or 3.
- R3: in_frame rises together with frame_start and stays high until carrier is low. Later bits, including pairs of equal bits, cause no further pulse.
- R4: Two consecutive zero bits during the preamble give a one-cycle preamble_bad pulse, in the cycle after the second zero, and no frame_start.
- R5: A delimiter that arrives while the run is shorter than N gives a preamble_bad pulse in place of frame_start.
- R6: After a preamble_bad pulse, all bits are discarded until carrier goes low. No frame_start or preamble_bad occurs in that time, even for a valid preamble that follows.
- R7: With len_sel equal to 0 at arming, neither frame_start nor preamble_bad is raised for that carrier period.
- R8: In any cycle with carrier low, the detector returns to IDLE and ignores bit_valid and bit_in. The next carrier-high cycle rearms it, and that first cycle takes no bit.
- R9: len_sel is sampled only in the cycle that leaves IDLE. Changes to it later in the same carrier period have no effect.
- R10: bit_in has no effect in cycles where bit_valid is low.
- R11: The run may start with either a one or a zero, and a run longer than N is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier | input | 1 | Line activity; low returns the detector to IDLE |
| bit_valid | input | 1 | bit_in holds a received bit in this cycle |
| bit_in | input | 1 | Recovered serial bit |
| len_sel | input | 2 | Preamble length select: 0 unsupported, 1/2/3 short/mid/long |
| frame_start | output | 1 | One-cycle pulse after an accepted start delimiter |
| preamble_bad | output | 1 | One-cycle pulse after a rejected preamble |
| in_frame | output | 1 | High from frame start until carrier drops |

## Verification
The bench builds the block with its default lengths of 8, 32 and 64. All three selects are therefore exercised, including the longest run, with saturation of the run counter well past the limit. Random frames mix runs that are too short, exactly long enough and overlong, and runs with two zeros placed inside them. Random idle cycles carry random bit values. A bench model predicts the bit at which the single pulse should appear. Directed cases cover select 0, a select change after arming, and a carrier drop in the middle of a run.

// File: rtl/pdet_pkg.sv
package pdet_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_FRAME   = 3'd2,
        ST_DISCARD = 3'd3,
        ST_UNSUP   = 3'd4
    } pdet_state_e;

    // Classification of the current bit against the previous one
    typedef enum logic [2:0] {
        BC_FIRST  = 3'd0,
        BC_ALT    = 3'd1,
        BC_TWO_0  = 3'd2,
        BC_TWO_1  = 3'd3
    } bit_class_e;

endpackage

// File: rtl/pdet_len_latch.sv
module pdet_len_latch #(
    parameter int LEN_SHORT = 8,
    parameter int LEN_MID   = 32,
    parameter int LEN_LONG  = 64,
    parameter int CW        = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    len_sel,
    output logic          sel_zero,
    output logic [CW-1:0] target
);

    localparam logic [CW-1:0] T_SHORT = CW'(LEN_SHORT);
    localparam logic [CW-1:0] T_MID   = CW'(LEN_MID);
    localparam logic [CW-1:0] T_LONG  = CW'(LEN_LONG);

    logic [CW-1:0] decoded;
    logic [CW-1:0] target_q;

    always_comb begin
        unique case (len_sel)
            2'd1:    decoded = T_SHORT;
            2'd2:    decoded = T_MID;
            2'd3:    decoded = T_LONG;
            default: decoded = '0;
        endcase
    end

    assign sel_zero = (len_sel == 2'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (load) begin
            target_q <= decoded;
        end
    end

    assign target = target_q;

    // R9
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(target));

endmodule

// File: rtl/pdet_bit_class.sv
module pdet_bit_class
    import pdet_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          take,
    input  logic          bit_in,
    input  logic [CW-1:0] target,
    output bit_class_e    cls,
    output logic          run_met
);

    logic          have_prev_q;
    logic          prev_q;
    logic [CW-1:0] count_q;

    always_comb begin
        if (!have_prev_q) begin
            cls = BC_FIRST;
        end else if (bit_in != prev_q) begin
            cls = BC_ALT;
        end else if (bit_in) begin
            cls = BC_TWO_1;
        end else begin
            cls = BC_TWO_0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_prev_q <= 1'b0;
            prev_q      <= 1'b0;
            count_q     <= '0;
        end else if (take) begin
            have_prev_q <= 1'b1;
            prev_q      <= bit_in;
            unique case (cls)
                BC_FIRST: count_q <= CW'(1);
                BC_ALT: begin
                    if (count_q < target) begin
                        count_q <= count_q + CW'(1);
                    end
                end
                default: count_q <= count_q;
            endcase
        end
    end

    assign run_met = (count_q >= target);

    // R11
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (take && count_q >= target && target != '0) |=> (count_q == $past(count_q)));

    // R2
    first_restart_chk: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (take && !have_prev_q) |=> (count_q == CW'(1)));

endmodule

// File: rtl/pdet_fsm.sv
module pdet_fsm
    import pdet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        carrier,
    input  logic        bit_valid,
    input  logic        bit_in,
    input  logic        sel_zero,
    input  bit_class_e  cls,
    input  logic        run_met,
    output pdet_state_e state,
    output logic        load,
    output logic        clear,
    output logic        take,
    output logic        frame_start,
    output logic        preamble_bad,
    output logic        in_frame
);

    pdet_state_e state_q;
    pdet_state_e state_n;
    logic        ev_start;
    logic        ev_bad;
    logic        start_q;
    logic        bad_q;
    logic        frame_q;

    assign take  = (state_q == ST_RUN) && carrier && bit_valid;
    assign clear = (state_q == ST_IDLE);
    assign load  = (state_q == ST_IDLE) && carrier;

    // Next-state and event decode
    always_comb begin
        state_n  = state_q;
        ev_start = 1'b0;
        ev_bad   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (carrier) begin
                    state_n = sel_zero ? ST_UNSUP : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!carrier) begin
                    state_n = ST_IDLE;
                end else if (bit_valid) begin
                    unique case (cls)
                        BC_TWO_0: begin
                            state_n = ST_DISCARD;
                            ev_bad  = 1'b1;
                        end
                        BC_TWO_1: begin
                            if (run_met) begin
                                state_n  = ST_FRAME;
                                ev_start = 1'b1;
                            end else begin
                                state_n = ST_DISCARD;
                                ev_bad  = 1'b1;
                            end
                        end
                        default: state_n = ST_RUN;
                    endcase
                end
            end
            ST_FRAME, ST_DISCARD, ST_UNSUP: begin
                if (!carrier) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            bad_q   <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            start_q <= ev_start;
            bad_q   <= ev_bad;
            frame_q <= (state_n == ST_FRAME);
        end
    end

    assign state        = state_q;
    assign frame_start  = start_q;
    assign preamble_bad = bad_q;
    assign in_frame     = frame_q;

    // R2
    fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R2
    fs_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(bit_valid && bit_in && carrier));

    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && carrier) |=> in_frame);

    // R3
    fs_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> in_frame);

    // R4
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && preamble_bad));

    // R6
    discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD) |=> (!frame_start && !preamble_bad));

    // R8
    drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier |=> (state_q == ST_IDLE && !in_frame && !frame_start && !preamble_bad));

    // R10
    no_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> (!frame_start && !preamble_bad));

endmodule

// File: rtl/preamble_detector.sv
module preamble_detector
    import pdet_pkg::*;
#(
    parameter int LEN_SHORT = 8,
    parameter int LEN_MID   = 32,
    parameter int LEN_LONG  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carrier,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic [1:0] len_sel,
    output logic       frame_start,
    output logic       preamble_bad,
    output logic       in_frame
);

    localparam int CW = $clog2(LEN_LONG + 1);

    logic          load;
    logic          clear;
    logic          take;
    logic          sel_zero;
    logic [CW-1:0] target;
    logic          run_met;
    bit_class_e    cls;
    pdet_state_e   state;

    pdet_len_latch #(
        .LEN_SHORT (LEN_SHORT),
        .LEN_MID   (LEN_MID),
        .LEN_LONG  (LEN_LONG),
        .CW        (CW)
    ) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .len_sel  (len_sel),
        .sel_zero (sel_zero),
        .target   (target)
    );

    pdet_bit_class #(
        .CW (CW)
    ) u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .take    (take),
        .bit_in  (bit_in),
        .target  (target),
        .cls     (cls),
        .run_met (run_met)
    );

    pdet_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .carrier      (carrier),
        .bit_valid    (bit_valid),
        .bit_in       (bit_in),
        .sel_zero     (sel_zero),
        .cls          (cls),
        .run_met      (run_met),
        .state        (state),
        .load         (load),
        .clear        (clear),
        .take         (take),
        .frame_start  (frame_start),
        .preamble_bad (preamble_bad),
        .in_frame     (in_frame)
    );

    // R7
    unsup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNSUP) |=> (!frame_start && !preamble_bad));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!frame_start && !preamble_bad && !in_frame));

endmodule

// File: tb/tb_preamble_detector.sv
`timescale 1ns/1ps
module tb_preamble_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic [1:0] len_sel = 2'd1;
    logic       frame_start;
    logic       preamble_bad;
    logic       in_frame;

    int n_checks = 0;
    int n_fail   = 0;

    bit fb [0:255];
    int flen = 0;

    always #2 clk = ~clk;

    preamble_detector dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .carrier      (carrier),
        .bit_valid    (bit_valid),
        .bit_in       (bit_in),
        .len_sel      (len_sel),
        .frame_start  (frame_start),
        .preamble_bad (preamble_bad),
        .in_frame     (in_frame)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int sel2n(input int s);
        case (s)
            1: return 8;
            2: return 32;
            3: return 64;
            default: return 0;
        endcase
    endfunction

    // kind: 0 none, 1 start, 2 bad (double zero), 3 bad (short run)
    function automatic void predict(input int n, output int kind, output int idx);
        int cnt = 0;
        int prev = 0;
        kind = 0;
        idx  = -1;
        if (n == 0) return;
        for (int i = 0; i < flen; i++) begin
            if (cnt == 0) begin
                cnt = 1;
                prev = fb[i];
            end else if (fb[i] != prev) begin
                cnt++;
                prev = fb[i];
            end else if (fb[i] == 0) begin
                kind = 2; idx = i; return;
            end else begin
                kind = (cnt >= n) ? 1 : 3;
                idx = i;
                return;
            end
        end
    endfunction

    // Alternating run of length L ending in 1, then the delimiter 1, then tail
    task automatic build_good(input int L, input int tail);
        flen = 0;
        for (int j = 0; j < L; j++) begin
            fb[flen] = ((L - 1 - j) % 2 == 0);
            flen++;
        end
        fb[flen] = 1'b1; flen++;
        for (int j = 0; j < tail; j++) begin
            fb[flen] = 1'($urandom);
            flen++;
        end
    endtask

    task automatic run_frame(input int sel, input int sel_late, input string tag);
        int kind;
        int idx;
        int g;
        predict(sel2n(sel), kind, idx);
        @(negedge clk);
        carrier = 1'b1;
        len_sel = 2'(sel);
        bit_valid = 1'b0;
        @(negedge clk);
        len_sel = 2'(sel_late);
        for (int i = 0; i < flen; i++) begin
            bit_valid = 1'b1;
            bit_in = fb[i];
            @(posedge clk);
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in = 1'($urandom);
            chk(frame_start == (kind == 1 && idx == i), tag, frame_start, (kind == 1 && idx == i));
            chk(preamble_bad == (kind >= 2 && idx == i), tag, preamble_bad, (kind >= 2 && idx == i));
            g = $urandom % 3;
            for (int k = 0; k < g; k++) begin
                bit_in = 1'($urandom);
                @(negedge clk);
                // R10: idle cycles with random bit_in raise nothing
                chk(!frame_start && !preamble_bad, "R10", frame_start + 2 * preamble_bad, 0);
            end
        end
        // R3
        chk(in_frame == (kind == 1), "R3", in_frame, (kind == 1));
        carrier = 1'b0;
        bit_valid = 1'b1;
        bit_in = 1'b1;
        @(negedge clk);
        // R8
        chk(!in_frame && !frame_start && !preamble_bad, "R8", in_frame, 0);
        bit_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c0d));
        repeat (3) @(negedge clk);
        // R1
        chk(!frame_start && !preamble_bad && !in_frame, "R1", frame_start + preamble_bad + in_frame, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!frame_start && !preamble_bad && !in_frame, "R1", frame_start + preamble_bad + in_frame, 0);

        // R2: exact-length runs for each select
        for (int s = 1; s <= 3; s++) begin
            build_good(sel2n(s), 4);
            run_frame(s, s, "R2");
        end
        // R11: long run starting with 0 and with 1
        build_good(sel2n(1) + 20, 3);
        run_frame(1, 1, "R11");
        build_good(sel2n(2) + 7, 3);
        run_frame(2, 2, "R11");
        // R5: one bit short
        build_good(sel2n(1) - 1, 2);
        run_frame(1, 1, "R5");
        // R4: two zeros inside the run
        build_good(sel2n(1) + 4, 2);
        fb[2] = 1'b0; fb[3] = 1'b0;
        run_frame(1, 1, "R4");
        // R6: early double zero then a valid preamble in the same carrier period
        flen = 0;
        fb[0] = 1; fb[1] = 0; fb[2] = 0; flen = 3;
        for (int j = 0; j < 12; j++) begin fb[flen] = (j % 2 == 0); flen++; end
        fb[flen] = 1; flen++;
        run_frame(1, 1, "R6");
        // R7: select 0
        build_good(12, 4);
        run_frame(0, 0, "R7");
        // R9: select changed after arming
        build_good(sel2n(1) + 1, 2);
        run_frame(1, 3, "R9");
        // R3: tail with equal pairs after the delimiter
        build_good(sel2n(1), 0);
        fb[flen] = 0; fb[flen+1] = 0; fb[flen+2] = 1; fb[flen+3] = 1; flen += 4;
        run_frame(1, 1, "R3");

        // R8: carrier drop mid-run, then a fresh valid frame
        @(negedge clk);
        carrier = 1'b1; len_sel = 2'd1;
        @(negedge clk);
        for (int j = 0; j < 6; j++) begin
            bit_valid = 1'b1; bit_in = 1'(j % 2);
            @(negedge clk);
        end
        carrier = 1'b0; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        chk(!frame_start && !preamble_bad && !in_frame, "R8", frame_start + preamble_bad, 0);
        bit_valid = 1'b0;
        @(negedge clk);
        build_good(sel2n(1), 2);
        run_frame(1, 1, "R8");

        // Random frames
        for (int f = 0; f < 40; f++) begin
            int s;
            int n;
            int t;
            s = 1 + ($urandom % 3);
            n = sel2n(s);
            t = $urandom % 4;
            case (t)
                0: build_good(n + ($urandom % 6), $urandom % 6);
                1: build_good((n > 3) ? n - 1 - ($urandom % 3) : 1, 2);
                2: begin
                    int p;
                    build_good(n + 2, 2);
                    p = $urandom % (n - 1);
                    if (fb[p] == 1'b1) p++;
                    fb[p + 1] = 1'b0;
                end
                default: begin
                    flen = 20;
                    for (int j = 0; j < 20; j++) fb[j] = 1'($urandom);
                end
            endcase
            run_frame(s, s, "R2/R4/R5");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule